// File: doc/BRIEF.md
# Dual-Channel Register Access Router

This block is the host-side front end of a two-channel serial controller. A parallel CPU bus carries an active-low chip select, a channel select, a register address, write data and active-low read and write strobes. The block decodes these signals. It then steers each read or write to one of two identical per-channel register banks: A, or B. The serial engines, FIFOs, baud generation and interrupts sit outside this block and take the bank contents as their configuration.

Each channel has its own set of general registers, at every address except the top one. One shared alternate-function register sits at the top address and can be reached from either channel select. Its bit 0 turns on broadcast mode. In broadcast mode a single write cycle updates the addressed register in both banks, so software can initialize both channels with one pass. Reads ignore broadcast mode and always follow the channel select. A write commits on the rising edge of the write strobe. This edge is detected in the clock domain, using the address, data and selects sampled while the strobe was low.

Top module: `dual_chan_reg_router`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, every general register of both banks reads 0, and the shared alternate-function register (address 7) reads 0, so broadcast is off.
- R2: While `cs_ni` is 1, a write cycle changes no register, and `rdata_o` is 0.
- R3: With `cs_ni` at 0 and broadcast off, `chan_sel_i` = 1 selects channel A for reads and writes, and channel B is left unchanged.
- R4: With `cs_ni` at 0 and broadcast off, `chan_sel_i` = 0 selects channel B for reads and writes, and channel A is left unchanged.
- R5: When bit 0 of the alternate-function register is 1, a write to any general address (0 to 6) stores the same data in that register of both channels, whatever the value of `chan_sel_i`.
- R6: Broadcast mode has no effect on reads: a read returns the register of the channel named by `chan_sel_i`.
- R7: Address 7 is one alternate-function register shared by both channels. A write from either select updates it, a read from either select returns it, and writing 0 to bit 0 turns broadcast off again.
- R8: While `rd_ni` is 1, `rdata_o` is 0. While `cs_ni` and `rd_ni` are both 0, `rdata_o` shows the addressed register in the same cycle.
- R9: A register keeps its old value while `wr_ni` stays low. The new value is visible one clock after `wr_ni` returns high, provided `cs_ni` was 0 during the low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| chan_sel_i | input | 1 | Channel select: 1 = A, 0 = B |
| addr_i | input | 3 | Register address; 7 = alternate-function register |
| wdata_i | input | 8 | Write data |
| rd_ni | input | 1 | Active-low read strobe |
| wr_ni | input | 1 | Active-low write strobe |
| rdata_o | output | 8 | Read data; 0 when no read is active |

## Verification
The assertions assume that the bus inputs change only between clock edges. They also assume that each write strobe stays low for at least one full clock, so that its rise is seen as a single edge. The bench drives every input on the falling clock edge and holds each strobe low for a whole cycle. It also keeps chip select, address and data steady across the low phase of the strobe. No read is overlapped with a committing write except in the strobe-timing scenario, which does this on purpose to watch the old value.

// File: rtl/drr_pkg.sv
package drr_pkg;
  typedef enum logic {CH_B = 1'b0, CH_A = 1'b1} chan_e;
  localparam int unsigned BCAST_BIT = 0;
  localparam int unsigned NUM_CH = 2;
endpackage

// File: rtl/drr_bus_capture.sv
module drr_bus_capture #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_ni,
  output logic          commit_o,
  output logic          sel_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic wr_q, cs_q;

  // bus fields latched during the low phase of the strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= 1'b1;
      cs_q   <= 1'b1;
      sel_o  <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      wr_q <= wr_ni;
      if (!wr_ni) begin
        cs_q   <= cs_ni;
        sel_o  <= sel_i;
        addr_o <= addr_i;
        data_o <= wdata_i;
      end
    end
  end

  assign commit_o = wr_ni & ~wr_q & ~cs_q;
endmodule

// File: rtl/drr_reg_bank.sv
module drr_reg_bank #(
  parameter int unsigned AW   = 3,
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            data_i,
  output logic [NREG-1:0][DW-1:0]  regs_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      regs_o <= '0;
    end else if (we_i) begin
      for (int i = 0; i < NREG; i++) begin
        if (addr_i == AW'(i)) regs_o[i] <= data_i;
      end
    end
  end
endmodule

// File: rtl/drr_read_mux.sv
module drr_read_mux #(
  parameter int unsigned AW   = 3,
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 7
) (
  input  logic                    cs_ni,
  input  logic                    rd_ni,
  input  logic                    sel_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [NREG-1:0][DW-1:0] bank_a_i,
  input  logic [NREG-1:0][DW-1:0] bank_b_i,
  input  logic [DW-1:0]           afr_i,
  output logic [DW-1:0]           rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (!cs_ni && !rd_ni) begin
      if (addr_i == AW'(NREG)) rdata_o = afr_i;
      else if (sel_i)          rdata_o = bank_a_i[addr_i];
      else                     rdata_o = bank_b_i[addr_i];
    end
  end
endmodule

// File: rtl/dual_chan_reg_router.sv
module dual_chan_reg_router #(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          chan_sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_ni,
  input  logic          wr_ni,
  output logic [DW-1:0] rdata_o
);
  import drr_pkg::*;

  localparam int unsigned NREG = (1 << AW) - 1;

  logic                    commit, sel_q, afr_hit, bcast;
  logic [AW-1:0]           addr_q;
  logic [DW-1:0]           data_q, afr_q;
  logic [NUM_CH-1:0]       we;
  logic [NREG-1:0][DW-1:0] bank [NUM_CH];
  logic                    we_a, we_b;
  logic [NREG-1:0][DW-1:0] bank_a, bank_b;

  drr_bus_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .sel_i    (chan_sel_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .wr_ni    (wr_ni),
    .commit_o (commit),
    .sel_o    (sel_q),
    .addr_o   (addr_q),
    .data_o   (data_q)
  );

  assign afr_hit = (addr_q == AW'(NREG));
  assign bcast   = afr_q[BCAST_BIT];

  // shared alternate-function register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                afr_q <= '0;
    else if (commit && afr_hit) afr_q <= data_q;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // broadcast overrides the select on writes only
    assign we[c] = commit & ~afr_hit & (bcast | (sel_q == c[0]));

    drr_reg_bank #(.AW(AW), .DW(DW), .NREG(NREG)) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (we[c]),
      .addr_i (addr_q),
      .data_i (data_q),
      .regs_o (bank[c])
    );
  end

  assign we_a   = we[CH_A];
  assign we_b   = we[CH_B];
  assign bank_a = bank[CH_A];
  assign bank_b = bank[CH_B];

  drr_read_mux #(.AW(AW), .DW(DW), .NREG(NREG)) u_rmux (
    .cs_ni    (cs_ni),
    .rd_ni    (rd_ni),
    .sel_i    (chan_sel_i),
    .addr_i   (addr_i),
    .bank_a_i (bank_a),
    .bank_b_i (bank_b),
    .afr_i    (afr_q),
    .rdata_o  (rdata_o)
  );
endmodule

// File: rtl/drr_checker.sv
module drr_checker #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NREG = 7
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cs_ni,
  input logic                    rd_ni,
  input logic                    wr_ni,
  input logic [DW-1:0]           rdata_o,
  input logic                    we_a,
  input logic                    we_b,
  input logic                    bcast,
  input logic [NREG-1:0][DW-1:0] bank_a,
  input logic [NREG-1:0][DW-1:0] bank_b
);
  // R2
  cs_idle_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> rdata_o == '0);
  // R8
  rd_idle_rdata_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ni |-> rdata_o == '0);
  // R5
  dual_write_needs_bcast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_a && we_b) |-> bcast);
  // R3
  single_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((we_a || we_b) && !bcast) |-> $onehot({we_a, we_b}));
  // R9
  write_on_strobe_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_a || we_b) |-> (wr_ni && !$past(wr_ni)));
  // R2
  bank_a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_a |=> $stable(bank_a));
  // R4
  bank_b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_b |=> $stable(bank_b));
endmodule

bind dual_chan_reg_router drr_checker #(.DW(DW), .NREG(NREG)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_ni   (cs_ni),
  .rd_ni   (rd_ni),
  .wr_ni   (wr_ni),
  .rdata_o (rdata_o),
  .we_a    (we_a),
  .we_b    (we_b),
  .bcast   (bcast),
  .bank_a  (bank_a),
  .bank_b  (bank_b)
);

// File: tb/dual_chan_reg_router_bench.sv
module dual_chan_reg_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 7;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_ni = 1'b1, chan_sel_i = 1'b0, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;

  int n_tests = 0, n_fail = 0;
  logic [7:0] ref_a [NREG];
  logic [7:0] ref_b [NREG];
  logic [7:0] ref_afr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_chan_reg_router u_dual_chan_reg_router (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .chan_sel_i(chan_sel_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .rdata_o(rdata_o));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_ni = 1'b1; rd_ni = 1'b1; wr_ni = 1'b1;
  endtask

  task automatic bus_write(input logic cs_n, input logic sel, input logic [2:0] a,
                           input logic [7:0] d);
    @(negedge clk);
    cs_ni = cs_n; chan_sel_i = sel; addr_i = a; wdata_i = d; wr_ni = 1'b0;
    @(negedge clk);
    wr_ni = 1'b1;
    @(negedge clk);
    idle();
    if (!cs_n) begin
      if (a == 3'd7) ref_afr = d;
      else begin
        if (ref_afr[0] || sel)  ref_a[a] = d;
        if (ref_afr[0] || !sel) ref_b[a] = d;
      end
    end
  endtask

  task automatic read_chk(input string req, input logic sel, input logic [2:0] a,
                          input logic [7:0] exp);
    @(negedge clk);
    cs_ni = 1'b0; chan_sel_i = sel; addr_i = a; rd_ni = 1'b0;
    #(CLK_PERIOD/4);
    check(req, rdata_o, exp);
    idle();
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < NREG; i++) begin
      read_chk(req, 1'b1, 3'(i), ref_a[i]);
      read_chk(req, 1'b0, 3'(i), ref_b[i]);
    end
    read_chk(req, 1'b1, 3'd7, ref_afr);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NREG; i++) begin ref_a[i] = '0; ref_b[i] = '0; end
    ref_afr = '0;
    read_all("R1 reset");
  endtask

  task automatic t_single_a();
    for (int i = 0; i < NREG; i++) bus_write(1'b0, 1'b1, 3'(i), 8'hA0 + 8'(i));
    read_all("R3 single A");
  endtask

  task automatic t_single_b();
    for (int i = 0; i < NREG; i++) bus_write(1'b0, 1'b0, 3'(i), 8'h50 ^ 8'(i * 3));
    read_all("R4 single B");
  endtask

  task automatic t_cs_inactive();
    bus_write(1'b1, 1'b1, 3'd2, 8'hFF);
    bus_write(1'b1, 1'b0, 3'd5, 8'h11);
    bus_write(1'b1, 1'b0, 3'd7, 8'h01);
    read_all("R2 cs inactive write");
    @(negedge clk);
    cs_ni = 1'b1; rd_ni = 1'b0; chan_sel_i = 1'b1; addr_i = 3'd0;
    #(CLK_PERIOD/4);
    check("R2 cs inactive rdata", rdata_o, 8'h00);
    idle();
  endtask

  task automatic t_rd_idle();
    @(negedge clk);
    cs_ni = 1'b0; rd_ni = 1'b1; chan_sel_i = 1'b1; addr_i = 3'd0;
    #(CLK_PERIOD/4);
    check("R8 rd idle", rdata_o, 8'h00);
    idle();
  endtask

  task automatic t_bcast();
    bus_write(1'b0, 1'b0, 3'd7, 8'h01);
    read_chk("R7 afr via B", 1'b0, 3'd7, 8'h01);
    bus_write(1'b0, 1'b0, 3'd1, 8'h3C);
    bus_write(1'b0, 1'b1, 3'd4, 8'hC3);
    bus_write(1'b0, 1'b0, 3'd6, 8'h77);
    read_all("R5 broadcast");
    // R6: diverge via broadcast off, then reads follow select with broadcast on
    bus_write(1'b0, 1'b1, 3'd7, 8'h00);
    bus_write(1'b0, 1'b1, 3'd3, 8'hEE);
    bus_write(1'b0, 1'b0, 3'd3, 8'h22);
    bus_write(1'b0, 1'b1, 3'd7, 8'h81);
    read_chk("R6 read A in bcast", 1'b1, 3'd3, 8'hEE);
    read_chk("R6 read B in bcast", 1'b0, 3'd3, 8'h22);
  endtask

  task automatic t_afr_clear();
    bus_write(1'b0, 1'b1, 3'd7, 8'h80);
    read_chk("R7 afr via A", 1'b1, 3'd7, 8'h80);
    read_chk("R7 afr via B", 1'b0, 3'd7, 8'h80);
    bus_write(1'b0, 1'b1, 3'd2, 8'h9D);
    read_chk("R7 bcast cleared A", 1'b1, 3'd2, 8'h9D);
    read_chk("R7 bcast cleared B", 1'b0, 3'd2, ref_b[2]);
  endtask

  task automatic t_strobe_edge();
    @(negedge clk);
    cs_ni = 1'b0; chan_sel_i = 1'b1; addr_i = 3'd5; wdata_i = 8'h5A;
    wr_ni = 1'b0; rd_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R9 hold while strobe low", rdata_o, ref_a[5]);
    wr_ni = 1'b1;
    @(negedge clk);
    check("R9 update after rise", rdata_o, 8'h5A);
    idle();
    ref_a[5] = 8'h5A;
    read_chk("R9 other channel kept", 1'b0, 3'd5, ref_b[5]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_rd_idle();
    t_single_a();
    t_single_b();
    t_cs_inactive();
    t_bcast();
    t_afr_clear();
    t_strobe_edge();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule